// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits for a four-beat memory burst. When a burst begins, the starting offset is taken from the external address and presented at once. Each advance cycle moves the output to the next beat of the burst, and any cycle that neither starts nor advances a burst leaves the output unchanged. Suspended bursts, deselected cycles and sleep cycles all count as such cycles.

Two beat orderings are supported, and a single order input selects between them when the burst starts. In linear order the offset counts upward and wraps modulo four. In interleaved order the offset is the start value XOR a beat count that runs 0, 1, 2, 3. In both orders the burst returns to its start offset after four advances. The cycle-type decoding that produces the load and step controls lies outside this block.

Control is a two-state machine. ST_IDLE is entered at reset and means no burst has been loaded yet. ST_BURST holds a live burst. The transitions are: IDLE_TO_BURST on a load; BURST_RELOAD on a load while in ST_BURST, which restarts the burst; BURST_STEP on a step; BURST_HOLD when neither control is asserted; and IDLE_HOLD on any cycle in ST_IDLE without a load, including a step.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low, synchronous) and afterwards until the first load, addr_o is 0 and the sequencer is in ST_IDLE.
- R2: A cycle with load_i high makes addr_o equal to that cycle's start_i from the next cycle on, and it restarts the beat count at zero. load_i takes priority over step_i in the same cycle.
- R3: The ordering is sampled from order_i only in a load cycle (0 = linear, 1 = interleaved). A change of order_i during a burst has no effect on addr_o.
- R4: A cycle with neither load_i nor step_i leaves addr_o unchanged on the next cycle.
- R5: In linear order, after n steps since the load, addr_o equals (start + n) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R6: In interleaved order, after n steps since the load, addr_o equals start XOR (n mod 4). For example, start 1 gives 1, 0, 3, 2.
- R7: After four steps addr_o is back at the start offset, and further steps repeat the same sequence.
- R8: A step_i in ST_IDLE is ignored, and addr_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start a new burst from start_i |
| step_i | input | 1 | Advance to the next beat |
| order_i | input | 1 | Ordering for a new burst: 0 linear, 1 interleaved |
| start_i | input | 2 | Starting offset from the external address |
| addr_o | output | 2 | Current burst offset |

## Verification
The embedded assertions check on every cycle that a load presents its start offset, that a hold cycle keeps the offset, that each step moves by exactly one position in the latched order, and that the output is zero in ST_IDLE. The bench's scenarios cover the rest. It sweeps both orders and all four start values through six steps to show the wrap and its repetition. It inserts hold cycles in mid-burst and flips order_i in mid-burst to show the order is latched. It also covers a step before any load and a load and step in the same cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } seq_op_e;
endpackage

// File: rtl/burst_op_sel.sv
module burst_op_sel
    import burst_seq_pkg::*;
(
    input  logic    load_i,
    input  logic    step_i,
    output seq_op_e op_o
);
    always_comb begin
        if (load_i)
            op_o = OP_LOAD;
        else if (step_i)
            op_o = OP_STEP;
        else
            op_o = OP_HOLD;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 advance_i,
    output logic [BEAT_BITS-1:0] beat_o
);
    typedef logic [BEAT_BITS-1:0] beat_t;
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (clear_i)
            beat_q <= '0;
        else if (advance_i)
            beat_q <= beat_q + beat_t'(1);
    end

    assign beat_o = beat_q;

    AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> beat_o == '0); // R2
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !clear_i) |=> beat_o == beat_t'($past(beat_o) + beat_t'(1))); // R7
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic [BEAT_BITS-1:0] start_i,
    input  logic [BEAT_BITS-1:0] beat_i,
    input  order_e               order_i,
    output logic [BEAT_BITS-1:0] addr_o
);
    logic [BEAT_BITS-1:0] lin_addr;
    logic [BEAT_BITS-1:0] ilv_addr;

    assign lin_addr = start_i + beat_i;

    for (genvar b = 0; b < BEAT_BITS; b++) begin : g_ilv_bit
        assign ilv_addr[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_LINEAR:     addr_o = lin_addr;
            ORD_INTERLEAVE: addr_o = ilv_addr;
            default:        addr_o = lin_addr;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic                 order_i,
    input  logic [BEAT_BITS-1:0] start_i,
    output logic [BEAT_BITS-1:0] addr_o
);
    typedef logic [BEAT_BITS-1:0] ofs_t;

    seq_state_e state_q, state_d;
    seq_op_e    op;
    ofs_t       start_q;
    order_e     order_q;
    ofs_t       beat;
    ofs_t       mapped;
    logic       advance;

    burst_op_sel u_op_sel (
        .load_i (load_i),
        .step_i (step_i),
        .op_o   (op)
    );

    assign advance = (op == OP_STEP) && (state_q == ST_BURST);

    burst_beat_ctr #(.BEAT_BITS(BEAT_BITS)) u_beat_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (op == OP_LOAD),
        .advance_i (advance),
        .beat_o    (beat)
    );

    burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_order_map (
        .start_i (start_q),
        .beat_i  (beat),
        .order_i (order_q),
        .addr_o  (mapped)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op == OP_LOAD) state_d = ST_BURST;  // IDLE_TO_BURST
            ST_BURST: state_d = ST_BURST;                     // RELOAD / STEP / HOLD
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register plus burst context captured on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            order_q <= ORD_LINEAR;
        end else begin
            state_q <= state_d;
            if (op == OP_LOAD) begin
                start_q <= start_i;
                order_q <= order_e'(order_i);
            end
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_IDLE:  addr_o = '0;
            ST_BURST: addr_o = mapped;
            default:  addr_o = '0;
        endcase
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> addr_o == '0); // R1
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_i)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o)); // R4
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && state_q == ST_BURST && order_q == ORD_LINEAR)
        |=> addr_o == ofs_t'($past(addr_o) + ofs_t'(1))); // R5
    AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && state_q == ST_BURST && order_q == ORD_INTERLEAVE)
        |=> (addr_o ^ start_q) == ofs_t'($past(beat) + ofs_t'(1))); // R6
    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_i) |=> state_q == ST_IDLE); // R8
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       step_i = 1'b0;
    logic       order_i = 1'b0;
    logic [1:0] start_i = 2'd0;
    logic [1:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .step_i  (step_i),
        .order_i (order_i),
        .start_i (start_i),
        .addr_o  (addr_o)
    );

    task automatic cyc(input logic ld, input logic st, input logic ord, input logic [1:0] sa);
        load_i  = ld;
        step_i  = st;
        order_i = ord;
        start_i = sa;
        @(negedge clk);
    endtask

    task automatic check(input string req, input int exp);
        checks++;
        if (int'(addr_o) != exp) begin
            errors++;
            $display("FAIL %s: addr_o=%0d expected=%0d", req, addr_o, exp);
        end
    endtask

    function automatic int model(input int ord, input int sa, input int n);
        if (ord == 1) return sa ^ (n % 4);
        return (sa + n) % 4;
    endfunction

    initial begin
        @(negedge clk);
        cyc(0, 0, 0, 2'd0);
        check("R1 reset", 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 2'd3);
        check("R1 after reset", 0);
        cyc(0, 1, 0, 2'd2);
        check("R8 step in idle", 0);
        cyc(0, 1, 1, 2'd1);
        check("R8 second step in idle", 0);

        // sweep both orders and all start offsets through six steps
        for (int ord = 0; ord < 2; ord++) begin
            for (int sa = 0; sa < 4; sa++) begin
                cyc(1, 0, ord[0], sa[1:0]);
                check("R2 load", sa);
                for (int n = 1; n <= 6; n++) begin
                    cyc(0, 1, ord[0], 2'(3 - sa));
                    check(ord == 1 ? (n % 4 == 0 ? "R7 ilv wrap" : "R6 ilv step")
                                   : (n % 4 == 0 ? "R7 lin wrap" : "R5 lin step"),
                          model(ord, sa, n));
                    if (n == 2) begin
                        cyc(0, 0, ord[0], 2'(sa + 1));
                        check("R4 hold", model(ord, sa, n));
                        cyc(0, 0, ~ord[0], 2'(sa + 2));
                        check("R4 hold twice", model(ord, sa, n));
                    end
                end
            end
        end

        // order latched at load: flip order_i mid-burst
        cyc(1, 0, 1'b1, 2'd1);
        check("R2 load ilv", 1);
        cyc(0, 1, 1'b0, 2'd0);
        check("R3 order flip ignored", 0);
        cyc(0, 1, 1'b0, 2'd0);
        check("R3 order flip ignored", 3);
        cyc(0, 1, 1'b0, 2'd0);
        check("R3 order flip ignored", 2);

        // load has priority over step, and restarts the beat count
        cyc(1, 1, 1'b0, 2'd2);
        check("R2 load beats step", 2);
        cyc(0, 1, 1'b1, 2'd0);
        check("R2 beat restart", 3);
        cyc(1, 0, 1'b0, 2'd0);
        check("R2 reload mid burst", 0);
        cyc(0, 1, 1'b0, 2'd0);
        check("R5 after reload", 1);

        // reset returns to idle
        rst_n = 1'b0;
        cyc(0, 0, 0, 2'd0);
        check("R1 reset again", 0);
        rst_n = 1'b1;
        cyc(0, 1, 0, 2'd0);
        check("R8 step after reset", 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule